// File: doc/BRIEF.md
# Hardware Timestamp Push Capture

This block stamps rare events arriving on four asynchronous push inputs against a free-running 32-bit time counter. Each input is brought into the reference clock domain through a two-stage synchronizer. A rising edge on an enabled input produces one event record. The record holds the counter value, a fixed event type code and the number of the input that caused it. Records go into a 16-entry first-in first-out queue, and software drains that queue through a show-ahead pop interface.

The inputs can rise in the same cycle. When they do, the block writes them one per cycle, lowest input number first, and keeps the rest pending. If a record arrives while the queue is full, it is dropped and a sticky overrun flag is set. Software clears the flag with a one-cycle clear pulse. Each push input is expected to stay high for at least 10 reference clock periods, and to toggle rarely enough that software can keep up with the queue.

Top module: `push_stamp_capture`

## Requirements
- R1: After reset, evValid is 0, overrun is 0 and the time counter is 0.
- R2: The time counter goes up by exactly one on every clock edge after reset and wraps modulo 2^32.
- R3: An enabled input that goes from low to high produces exactly one record. An input held high produces no further records, and a falling edge produces none.
- R4: A record's evTime is the counter value two clock edges after the edge at which the input is first sampled high. Its evType is 4'b0001, and evPort is the input index, 0 to 3, on 3 bits.
- R5: A rise on an input whose enableMask bit is 0 produces no record.
- R6: Inputs that rise in the same cycle are written one per cycle in ascending index order. Their evTime values are therefore consecutive.
- R7: The queue holds 16 records in arrival order. evValid is 1 whenever it is non-empty, and the head record is shown on evTime, evType and evPort. popReq with evValid removes the head at the next clock edge. popReq on an empty queue is ignored.
- R8: A record that arrives while 16 records are held is discarded, and overrun becomes 1. overrun then stays 1 until it is cleared.
- R9: An ovfClr pulse clears overrun at the next edge. If a record is dropped in the same cycle, overrun stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushAsync | input | 4 | Asynchronous push inputs |
| enableMask | input | 4 | Per-input capture enable |
| popReq | input | 1 | Remove the head record |
| ovfClr | input | 1 | Clear the overrun flag (write-1 pulse) |
| evValid | output | 1 | Queue holds at least one record |
| evTime | output | 32 | Head record timestamp |
| evType | output | 4 | Head record event type |
| evPort | output | 3 | Head record input number |
| overrun | output | 1 | Sticky record-dropped flag |

## Verification
A table of push patterns is applied under several enable masks: a single input, all four together, a sparse pair, masked-off inputs and a fully disabled mask. These patterns separate correct per-input tagging from wrong arbitration order and from enable bits that leak. Each pulse is held for many cycles and then released, so a design that stamps on level or on the falling edge produces extra records. A directed run pushes twenty events into the queue. It shows that exactly sixteen are kept in order, that the flag stays set after the queue is drained, and that the clear pulse resets it.

// File: rtl/push_stamp_pkg.sv
package push_stamp_pkg;
  localparam int PORT_W = 3;
  localparam int TYPE_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic             wr;
    logic [PORT_W-1:0] port;
    logic             pop;
    logic             clr;
  } stb_t;
endpackage

// File: rtl/push_stamp_ctrl.sv
module push_stamp_ctrl
  import push_stamp_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pushAsync,
  input  logic [NUM_IN-1:0] enableMask,
  input  logic              popReq,
  input  logic              ovfClr,
  output stb_t              strb,
  output logic [NUM_IN-1:0] grantVec
);
  logic [NUM_IN-1:0] syncA, syncB, prevB, pendVec;
  logic [NUM_IN-1:0] edgeVec, reqVec;
  logic [PORT_W-1:0] portSel;

  // two-flop synchronizer plus delayed copy for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevB   <= '0;
      pendVec <= '0;
    end else begin
      syncA   <= pushAsync;
      syncB   <= syncA;
      prevB   <= syncB;
      pendVec <= reqVec & ~grantVec;
    end
  end

  always_comb begin
    edgeVec  = syncB & ~prevB & enableMask;
    reqVec   = pendVec | edgeVec;
    grantVec = reqVec & (~reqVec + NUM_IN'(1));  // lowest set bit wins
  end

  always_comb begin
    portSel = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (grantVec[i]) portSel = PORT_W'(i);
  end

  always_comb begin
    strb.wr   = |grantVec;
    strb.port = portSel;
    strb.pop  = popReq;
    strb.clr  = ovfClr;
  end
endmodule

// File: rtl/push_stamp_dp.sv
module push_stamp_dp
  import push_stamp_pkg::*;
#(
  parameter int              DEPTH    = 16,
  parameter int              TS_W     = 32,
  parameter logic [TYPE_W-1:0] EVT_CODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              strb,
  output logic [TS_W-1:0]   timeNow,
  output logic              fifoFull,
  output logic              evValid,
  output logic [TS_W-1:0]   evTime,
  output logic [TYPE_W-1:0] evType,
  output logic [PORT_W-1:0] evPort,
  output logic              overrun
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [TS_W-1:0]   tsMem   [DEPTH];
  logic [TYPE_W-1:0] typeMem [DEPTH];
  logic [PORT_W-1:0] portMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  level;
  logic              wrOk, popOk;

  always_comb begin
    fifoFull = (level == CNT_W'(DEPTH));
    evValid  = (level != '0);
    wrOk     = strb.wr && !fifoFull;
    popOk    = strb.pop && evValid;
    evTime   = tsMem[rdPtr];
    evType   = typeMem[rdPtr];
    evPort   = portMem[rdPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeNow <= '0;
    else       timeNow <= timeNow + TS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (wrOk) begin
      tsMem[wrPtr]   <= timeNow;
      typeMem[wrPtr] <= EVT_CODE;
      portMem[wrPtr] <= strb.port;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wrOk)  wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popOk) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({wrOk, popOk})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
      if (strb.wr && fifoFull) overrun <= 1'b1;
      else if (strb.clr)       overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/push_stamp_capture.sv
module push_stamp_capture
  import push_stamp_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DEPTH  = 16,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pushAsync,
  input  logic [NUM_IN-1:0] enableMask,
  input  logic              popReq,
  input  logic              ovfClr,
  output logic              evValid,
  output logic [TS_W-1:0]   evTime,
  output logic [TYPE_W-1:0] evType,
  output logic [PORT_W-1:0] evPort,
  output logic              overrun
);
  stb_t              strb;
  logic [NUM_IN-1:0] grantVec;
  logic [TS_W-1:0]   timeNow;
  logic              fifoFull;

  push_stamp_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushAsync(pushAsync), .enableMask(enableMask),
    .popReq(popReq), .ovfClr(ovfClr), .strb(strb), .grantVec(grantVec)
  );

  push_stamp_dp #(.DEPTH(DEPTH), .TS_W(TS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeNow(timeNow),
    .fifoFull(fifoFull), .evValid(evValid), .evTime(evTime),
    .evType(evType), .evPort(evPort), .overrun(overrun)
  );
endmodule

// File: rtl/push_stamp_chk.sv
module push_stamp_chk #(
  parameter int NUM_IN = 4,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [TS_W-1:0]   timeNow,
  input logic [NUM_IN-1:0] grantVec,
  input logic              wrStb,
  input logic              fifoFull,
  input logic              ovfClr,
  input logic              overrun,
  input logic              evValid
);
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> timeNow == $past(timeNow) + TS_W'(1));

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  p_valid_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !fifoFull) |=> evValid);

  p_drop_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && fifoFull) |=> overrun);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovfClr) |=> overrun);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !(wrStb && fifoFull)) |=> !overrun);
endmodule

bind push_stamp_capture push_stamp_chk #(.NUM_IN(NUM_IN), .TS_W(TS_W)) u_chk (
  .clk(clk), .rstN(rstN), .timeNow(timeNow), .grantVec(grantVec),
  .wrStb(strb.wr), .fifoFull(fifoFull), .ovfClr(ovfClr),
  .overrun(overrun), .evValid(evValid)
);

// File: tb/push_stamp_capture_tb.sv
`timescale 1ns/1ps
module push_stamp_capture_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  pushAsync = '0;
  logic [3:0]  enableMask = '0;
  logic        popReq = 1'b0;
  logic        ovfClr = 1'b0;
  logic        evValid;
  logic [31:0] evTime;
  logic [3:0]  evType;
  logic [2:0]  evPort;
  logic        overrun;

  int checks = 0;
  int fails = 0;
  int unsigned tick = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) if (rstN) tick <= tick + 1;

  push_stamp_capture u_dut (
    .clk(clk), .rstN(rstN), .pushAsync(pushAsync), .enableMask(enableMask),
    .popReq(popReq), .ovfClr(ovfClr), .evValid(evValid), .evTime(evTime),
    .evType(evType), .evPort(evPort), .overrun(overrun)
  );

  // {push pattern, enable mask, expected record count}
  localparam logic [11:0] VEC [6] = '{
    {4'b0001, 4'b1111, 4'd1},
    {4'b1111, 4'b1111, 4'd4},
    {4'b1010, 4'b1111, 4'd2},
    {4'b0110, 4'b0100, 4'd1},
    {4'b1111, 4'b0000, 4'd0},
    {4'b1001, 4'b1001, 4'd2}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one pulse of the given pattern; returns the tick value at the drive
  task automatic pulse(input logic [3:0] pat, output int unsigned t0);
    @(negedge clk);
    pushAsync = pat;
    t0 = tick;
    waitCyc(12);
    pushAsync = '0;
    waitCyc(12);
  endtask

  task automatic popOne(input int expPort, input int unsigned expTs, input string req);
    check({req, " evValid"}, evValid, 1);
    check({req, " evPort"}, evPort, expPort);
    check({req, " evTime"}, evTime, expTs);
    check("R4 evType", evType, 4'b0001);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned t0;
    waitCyc(3);
    check("R1 evValid", evValid, 0);
    check("R1 overrun", overrun, 0);
    @(negedge clk);
    rstN = 1'b1;
    waitCyc(2);

    // R3 R4 R5 R6 table walk
    for (int v = 0; v < 6; v++) begin
      logic [3:0] pat, en;
      int k;
      pat = VEC[v][11:8];
      en = VEC[v][7:4];
      enableMask = en;
      pulse(pat, t0);
      k = 0;
      for (int i = 0; i < 4; i++) begin
        if (pat[i] && en[i]) begin
          popOne(i, t0 + 2 + k, "R3 R6");
          k++;
        end
      end
      check("R5 record count", k, VEC[v][3:0]);
      check("R3 no extra record", evValid, 0);
      check("R8 no false overrun", overrun, 0);
    end

    // R7 pop on empty is ignored
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    check("R7 empty pop", evValid, 0);

    // R8 overflow: 20 events into 16 entries
    enableMask = 4'b1111;
    begin
      int unsigned ts [5];
      for (int r = 0; r < 5; r++) pulse(4'b1111, ts[r]);
      check("R8 overrun set", overrun, 1);
      for (int j = 0; j < 16; j++)
        popOne(j % 4, ts[j / 4] + 2 + (j % 4), "R7 order");
    end
    check("R7 depth 16", evValid, 0);
    check("R8 sticky after drain", overrun, 1);

    // R9 clear
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check("R9 clear", overrun, 0);

    // R2 later stamp still tracks the counter
    pulse(4'b0100, t0);
    popOne(2, t0 + 2, "R2 counter");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule